// File: doc/BRIEF.md
# Integer Execute Unit: Arithmetic, Logic, Compare and Shift

This block is the purely combinational integer execute stage of a 32-bit load/store core with a fixed opcode/function-code instruction map. The core's decoder splits the instruction word into fields. It hands the block the primary opcode, the function code, the shift-amount field, the two register source values and the 16-bit immediate. The block answers in the same cycle with the value to be written back. The block covers three-register arithmetic, logic, compare and shift operations, and the register-immediate forms of add, compare, logic and load-upper.

Comparisons produce a 0 or 1 in the destination instead of setting condition flags. Variable shifts take their count from the first register operand. Signed and unsigned add/subtract produce the same 32-bit value, and no overflow trap is raised here. Any encoding outside the supported set drives a zero result and raises an unsupported indication. This lets a bench sweep the whole code space and find every encoding the block handles.

Top module: `alu_exec`

## Requirements
- R1: With opcode 000000, funct 100000 and funct 100001 both give rs+rt modulo 2^32, with the same result and no overflow indication.
- R2: With opcode 000000, funct 100010 and funct 100011 both give rs-rt modulo 2^32.
- R3: With opcode 000000, funct 100100 gives rs AND rt, 100101 gives rs OR rt, 100110 gives rs XOR rt and 100111 gives NOT(rs OR rt).
- R4: With opcode 000000, funct 101010 gives 1 when rs is less than rt as two's-complement numbers and funct 101011 gives 1 when rs is less than rt as unsigned numbers. Otherwise the result is 0, and bits 31:1 are always 0.
- R5: With opcode 000000, funct 000000 shifts rt left, 000010 shifts rt right filling with zeros and 000011 shifts rt right arithmetically, each by the 5-bit shift-amount field. The rs value has no effect.
- R6: With opcode 000000, funct 000100 (left), 000110 (logical right) and 000111 (arithmetic right) shift rt by rs[4:0]. Bits 31:5 of rs and the shift-amount field have no effect.
- R7: Both arithmetic right shifts copy rt bit 31 into every vacated bit position.
- R8: Opcodes 001000 and 001001 both give rs plus the sign-extended immediate, modulo 2^32.
- R9: Opcode 001010 gives 1 when rs is less than the sign-extended immediate, compared signed. Opcode 001011 sign-extends the immediate the same way and then compares unsigned. Otherwise the result is 0.
- R10: Opcode 001100 gives rs AND, 001101 gives rs OR and 001110 gives rs XOR the zero-extended immediate.
- R11: Opcode 001111 places the immediate in bits 31:16 and zeros in bits 15:0. The rs value has no effect.
- R12: Every other opcode, and every opcode-000000 function code not listed above, gives result 0 with unsupported_o at 1. Every listed encoding gives unsupported_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function code field, used when opcode is 000000 |
| shamt_i | input | 5 | Fixed shift-amount field |
| rs_val_i | input | 32 | First register source value |
| rt_val_i | input | 32 | Second register source value |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Value for writeback |
| unsupported_o | output | 1 | High when the encoding is not handled |

## Verification
Two sources of shift count are present at once: the instruction's shift-amount field and the low bits of rs. Only one of them may steer a given shift. The bench drives both with different, non-zero values on every shift encoding, so a variable shift carries a stray shift-amount field and high rs bits set. A fixed shift carries an unrelated rs. The result is compared with a model that reads only the legitimate source. Arithmetic right shifts are run with rt bit 31 both set and clear, so a swapped count and a lost sign fill show up as different values.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OPC_W = 6;

   // primary opcodes
   localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
   localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
   localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
   localparam logic [OPC_W-1:0] OPC_SLTIU = 6'b001011;
   localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
   localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
   localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
   localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;

   // function codes under OPC_REG
   localparam logic [OPC_W-1:0] FN_SLL  = 6'b000000;
   localparam logic [OPC_W-1:0] FN_SRL  = 6'b000010;
   localparam logic [OPC_W-1:0] FN_SRA  = 6'b000011;
   localparam logic [OPC_W-1:0] FN_SLLV = 6'b000100;
   localparam logic [OPC_W-1:0] FN_SRLV = 6'b000110;
   localparam logic [OPC_W-1:0] FN_SRAV = 6'b000111;
   localparam logic [OPC_W-1:0] FN_ADD  = 6'b100000;
   localparam logic [OPC_W-1:0] FN_ADDU = 6'b100001;
   localparam logic [OPC_W-1:0] FN_SUB  = 6'b100010;
   localparam logic [OPC_W-1:0] FN_SUBU = 6'b100011;
   localparam logic [OPC_W-1:0] FN_AND  = 6'b100100;
   localparam logic [OPC_W-1:0] FN_OR   = 6'b100101;
   localparam logic [OPC_W-1:0] FN_XOR  = 6'b100110;
   localparam logic [OPC_W-1:0] FN_NOR  = 6'b100111;
   localparam logic [OPC_W-1:0] FN_SLT  = 6'b101010;
   localparam logic [OPC_W-1:0] FN_SLTU = 6'b101011;

   typedef enum logic [3:0] {
      K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
      K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA, K_LUI, K_NONE
   } alu_kind_e;

   typedef enum logic [1:0] {
      SRC_RT, SRC_SIMM, SRC_ZIMM
   } bsrc_e;

   typedef struct packed {
      alu_kind_e kind;
      bsrc_e     bsrc;
      logic      amt_from_rs;
      logic      unsup;
   } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [OPC_W-1:0] funct_i,
   output alu_ctl_t         ctl_o
);

   always_comb begin
      ctl_o = '{kind: K_NONE, bsrc: SRC_RT, amt_from_rs: 1'b0, unsup: 1'b1};
      unique case (opcode_i)
         OPC_REG: begin
            ctl_o.unsup = 1'b0;
            unique case (funct_i)
               FN_ADD, FN_ADDU: ctl_o.kind = K_ADD;
               FN_SUB, FN_SUBU: ctl_o.kind = K_SUB;
               FN_AND:  ctl_o.kind = K_AND;
               FN_OR:   ctl_o.kind = K_OR;
               FN_XOR:  ctl_o.kind = K_XOR;
               FN_NOR:  ctl_o.kind = K_NOR;
               FN_SLT:  ctl_o.kind = K_SLT;
               FN_SLTU: ctl_o.kind = K_SLTU;
               FN_SLL:  ctl_o.kind = K_SLL;
               FN_SRL:  ctl_o.kind = K_SRL;
               FN_SRA:  ctl_o.kind = K_SRA;
               FN_SLLV: begin ctl_o.kind = K_SLL; ctl_o.amt_from_rs = 1'b1; end
               FN_SRLV: begin ctl_o.kind = K_SRL; ctl_o.amt_from_rs = 1'b1; end
               FN_SRAV: begin ctl_o.kind = K_SRA; ctl_o.amt_from_rs = 1'b1; end
               default: ctl_o.unsup = 1'b1;
            endcase
         end
         OPC_ADDI, OPC_ADDIU: ctl_o = '{K_ADD,  SRC_SIMM, 1'b0, 1'b0};
         OPC_SLTI:            ctl_o = '{K_SLT,  SRC_SIMM, 1'b0, 1'b0};
         OPC_SLTIU:           ctl_o = '{K_SLTU, SRC_SIMM, 1'b0, 1'b0};
         OPC_ANDI:            ctl_o = '{K_AND,  SRC_ZIMM, 1'b0, 1'b0};
         OPC_ORI:             ctl_o = '{K_OR,   SRC_ZIMM, 1'b0, 1'b0};
         OPC_XORI:            ctl_o = '{K_XOR,  SRC_ZIMM, 1'b0, 1'b0};
         OPC_LUI:             ctl_o = '{K_LUI,  SRC_ZIMM, 1'b0, 1'b0};
         default: ;
      endcase
   end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
   import alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
)(
   input  bsrc_e             bsrc_i,
   input  logic [DATA_W-1:0] rt_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] b_o,
   output logic [DATA_W-1:0] upper_o
);

   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] simm, zimm;

   assign simm    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign zimm    = {{EXT_W{1'b0}}, imm_i};
   assign upper_o = {imm_i, {EXT_W{1'b0}}};

   always_comb begin
      unique case (bsrc_i)
         SRC_SIMM: b_o = simm;
         SRC_ZIMM: b_o = zimm;
         default:  b_o = rt_i;
      endcase
   end

endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] sum_o,
   output logic [DATA_W-1:0] diff_o,
   output logic              lt_s_o,
   output logic              lt_u_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] diff_ext;

   assign sum_o    = a_i + b_i;
   // a + ~b + 1 ; carry out clear means a borrow, i.e. a < b unsigned
   assign diff_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
   assign diff_o   = diff_ext[MSB:0];
   assign lt_u_o   = ~diff_ext[DATA_W];
   assign lt_s_o   = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff_ext[MSB];

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int DATA_W = 32,
   parameter int IMPL   = 0,   // 0: logarithmic stages, 1: operator form
   localparam int AMT_W = $clog2(DATA_W)
)(
   input  logic [DATA_W-1:0] val_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic              right_i,
   input  logic              arith_i,
   output logic [DATA_W-1:0] res_o
);

   generate
      if (IMPL == 0) begin : g_stages
         logic [DATA_W-1:0] rev_in, src, rev_out;
         logic [DATA_W-1:0] stage [AMT_W+1];
         logic              fill;

         for (genvar b = 0; b < DATA_W; b++) begin : g_rev
            assign rev_in[b]  = val_i[DATA_W-1-b];
            assign rev_out[b] = stage[AMT_W][DATA_W-1-b];
         end

         // left shifts run through the right shifter on bit-reversed data
         assign src      = right_i ? val_i : rev_in;
         assign fill     = right_i & arith_i & val_i[DATA_W-1];
         assign stage[0] = src;

         for (genvar s = 0; s < AMT_W; s++) begin : g_lvl
            localparam int SH = 1 << s;
            assign stage[s+1] = amt_i[s]
               ? {{SH{fill}}, stage[s][DATA_W-1:SH]}
               : stage[s];
         end

         assign res_o = right_i ? stage[AMT_W] : rev_out;
      end else begin : g_ops
         logic signed [DATA_W-1:0] sval;
         assign sval = val_i;
         always_comb begin
            if (!right_i)     res_o = val_i << amt_i;
            else if (arith_i) res_o = sval >>> amt_i;
            else              res_o = val_i >> amt_i;
         end
      end
   endgenerate

endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int SHIFT_IMPL = 0,
   localparam int SHAMT_W   = $clog2(DATA_W)
)(
   input  logic [OPC_W-1:0]   opcode_i,
   input  logic [OPC_W-1:0]   funct_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic [DATA_W-1:0]  rs_val_i,
   input  logic [DATA_W-1:0]  rt_val_i,
   input  logic [IMM_W-1:0]   imm_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               unsupported_o
);

   generate
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("alu_exec: DATA_W must be a power of two");
      end
      if (DATA_W <= IMM_W) begin : g_bad_imm
         $error("alu_exec: DATA_W must exceed IMM_W");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("alu_exec: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   alu_ctl_t           ctl;
   logic [DATA_W-1:0]  b_val, upper, sum, diff, sh_res;
   logic               lt_s, lt_u;
   logic [SHAMT_W-1:0] sh_amt;
   logic [DATA_W-1:0]  res_raw;

   alu_decode u_dec (
      .opcode_i (opcode_i),
      .funct_i  (funct_i),
      .ctl_o    (ctl)
   );

   alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
      .bsrc_i  (ctl.bsrc),
      .rt_i    (rt_val_i),
      .imm_i   (imm_i),
      .b_o     (b_val),
      .upper_o (upper)
   );

   alu_arith #(.DATA_W(DATA_W)) u_arith (
      .a_i    (rs_val_i),
      .b_i    (b_val),
      .sum_o  (sum),
      .diff_o (diff),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   assign sh_amt = ctl.amt_from_rs ? rs_val_i[SHAMT_W-1:0] : shamt_i;

   alu_shift #(.DATA_W(DATA_W), .IMPL(SHIFT_IMPL)) u_shift (
      .val_i   (rt_val_i),
      .amt_i   (sh_amt),
      .right_i (ctl.kind inside {K_SRL, K_SRA}),
      .arith_i (ctl.kind == K_SRA),
      .res_o   (sh_res)
   );

   always_comb begin
      unique case (ctl.kind)
         K_ADD:  res_raw = sum;
         K_SUB:  res_raw = diff;
         K_AND:  res_raw = rs_val_i & b_val;
         K_OR:   res_raw = rs_val_i | b_val;
         K_XOR:  res_raw = rs_val_i ^ b_val;
         K_NOR:  res_raw = ~(rs_val_i | b_val);
         K_SLT:  res_raw = {{(DATA_W-1){1'b0}}, lt_s};
         K_SLTU: res_raw = {{(DATA_W-1){1'b0}}, lt_u};
         K_SLL, K_SRL, K_SRA: res_raw = sh_res;
         K_LUI:  res_raw = upper;
         default: res_raw = '0;
      endcase
   end

   assign result_o      = ctl.unsup ? '0 : res_raw;
   assign unsupported_o = ctl.unsup;

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int SHAMT_W = 5
)(
   input logic [5:0]         opcode_i,
   input logic [5:0]         funct_i,
   input logic [SHAMT_W-1:0] shamt_i,
   input logic [DATA_W-1:0]  rs_val_i,
   input logic [DATA_W-1:0]  rt_val_i,
   input logic [IMM_W-1:0]   imm_i,
   input logic [DATA_W-1:0]  result_o,
   input logic               unsupported_o
);

   always_comb begin
      if (unsupported_o)
         p_unsup_zero_r12: assert (result_o == '0)
            else $error("unsupported encoding produced a non-zero result");

      if (opcode_i == 6'b100011)
         p_unknown_opc_r12: assert (unsupported_o)
            else $error("foreign opcode not flagged");

      if (opcode_i == 6'b000000 && funct_i == 6'b100001)
         p_add_inverse_r1: assert (result_o - rt_val_i == rs_val_i)
            else $error("sum minus rt does not give rs");

      if (opcode_i == 6'b000000 && funct_i == 6'b100011)
         p_sub_inverse_r2: assert (result_o + rt_val_i == rs_val_i)
            else $error("difference plus rt does not give rs");

      if (opcode_i == 6'b000000 && (funct_i == 6'b101010 || funct_i == 6'b101011))
         p_cmp_bool_r4: assert (result_o[DATA_W-1:1] == '0)
            else $error("compare result wider than one bit");

      if (opcode_i == 6'b000000 && funct_i == 6'b000011 && shamt_i != '0)
         p_sra_sign_r7: assert (result_o[DATA_W-1] == rt_val_i[DATA_W-1])
            else $error("arithmetic shift lost the sign bit");

      if (opcode_i == 6'b001011)
         p_cmpi_bool_r9: assert (result_o[DATA_W-1:1] == '0)
            else $error("immediate compare result wider than one bit");

      if (opcode_i == 6'b001111)
         p_upper_place_r11: assert (result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}})
            else $error("load-upper value misplaced");
   end

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) chk_i (
   .opcode_i      (opcode_i),
   .funct_i       (funct_i),
   .shamt_i       (shamt_i),
   .rs_val_i      (rs_val_i),
   .rt_val_i      (rt_val_i),
   .imm_i         (imm_i),
   .result_o      (result_o),
   .unsupported_o (unsupported_o)
);

// File: tb/alu_exec_tb_top.sv
module alu_exec_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  opc = '0;
   logic [5:0]  fn  = '0;
   logic [4:0]  sa  = '0;
   logic [31:0] rs  = '0;
   logic [31:0] rt  = '0;
   logic [15:0] imm = '0;
   logic [31:0] res;
   logic        uns;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   alu_exec dut_i (
      .opcode_i      (opc),
      .funct_i       (fn),
      .shamt_i       (sa),
      .rs_val_i      (rs),
      .rt_val_i      (rt),
      .imm_i         (imm),
      .result_o      (res),
      .unsupported_o (uns)
   );

   // reference model: {unsupported, result}
   function automatic logic [32:0] model(input logic [5:0] o, input logic [5:0] f,
                                         input logic [4:0] s, input logic [31:0] a,
                                         input logic [31:0] b, input logic [15:0] i);
      logic signed [31:0] sa_v, sb_v, si_v;
      logic [31:0] se, ze;
      sa_v = a; sb_v = b;
      se = {{16{i[15]}}, i};
      ze = {16'h0, i};
      si_v = se;
      if (o == 6'd0) begin
         case (f)
            6'b100000, 6'b100001: return {1'b0, a + b};
            6'b100010, 6'b100011: return {1'b0, a - b};
            6'b100100: return {1'b0, a & b};
            6'b100101: return {1'b0, a | b};
            6'b100110: return {1'b0, a ^ b};
            6'b100111: return {1'b0, ~(a | b)};
            6'b101010: return {1'b0, 31'd0, sa_v < sb_v};
            6'b101011: return {1'b0, 31'd0, a < b};
            6'b000000: return {1'b0, b << s};
            6'b000010: return {1'b0, b >> s};
            6'b000011: return {1'b0, sb_v >>> s};
            6'b000100: return {1'b0, b << a[4:0]};
            6'b000110: return {1'b0, b >> a[4:0]};
            6'b000111: return {1'b0, sb_v >>> a[4:0]};
            default:   return {1'b1, 32'd0};
         endcase
      end
      case (o)
         6'b001000, 6'b001001: return {1'b0, a + se};
         6'b001010: return {1'b0, 31'd0, sa_v < si_v};
         6'b001011: return {1'b0, 31'd0, a < se};
         6'b001100: return {1'b0, a & ze};
         6'b001101: return {1'b0, a | ze};
         6'b001110: return {1'b0, a ^ ze};
         6'b001111: return {1'b0, i, 16'h0};
         default:   return {1'b1, 32'd0};
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] o, input logic [5:0] f);
      if (o == 6'd0) begin
         case (f)
            6'b100000, 6'b100001: return "R1";
            6'b100010, 6'b100011: return "R2";
            6'b100100, 6'b100101, 6'b100110, 6'b100111: return "R3";
            6'b101010, 6'b101011: return "R4";
            6'b000000, 6'b000010: return "R5";
            6'b000011: return "R5/R7";
            6'b000100, 6'b000110: return "R6";
            6'b000111: return "R6/R7";
            default: return "R12";
         endcase
      end
      case (o)
         6'b001000, 6'b001001: return "R8";
         6'b001010, 6'b001011: return "R9";
         6'b001100, 6'b001101, 6'b001110: return "R10";
         6'b001111: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check_now(input string tag, input logic [31:0] er, input logic eu);
      total++;
      if (res !== er || uns !== eu) begin
         bad++;
         $display("FAIL %s op=%b fn=%b sa=%0d rs=%h rt=%h imm=%h : got res=%h uns=%b exp res=%h uns=%b",
                  tag, opc, fn, sa, rs, rt, imm, res, uns, er, eu);
      end
   endtask

   task automatic run(input logic [5:0] o, input logic [5:0] f, input logic [4:0] s,
                      input logic [31:0] a, input logic [31:0] b, input logic [15:0] i,
                      input string tag);
      logic [32:0] exp_v;
      @(negedge clk);
      opc = o; fn = f; sa = s; rs = a; rt = b; imm = i;
      #5;
      exp_v = model(o, f, s, a, b, i);
      check_now(tag, exp_v[31:0], exp_v[32]);
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom % 8)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h8000_0000;
         3: return 32'hFFFF_FFFF;
         4: return 32'h7FFF_FFFF;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      logic [5:0] reg_fns [16];
      logic [5:0] imm_ops [8];
      void'($urandom(32'h5EED_0042));
      reg_fns = '{6'b100000, 6'b100001, 6'b100010, 6'b100011, 6'b100100, 6'b100101,
                  6'b100110, 6'b100111, 6'b101010, 6'b101011, 6'b000000, 6'b000010,
                  6'b000011, 6'b000100, 6'b000110, 6'b000111};
      imm_ops = '{6'b001000, 6'b001001, 6'b001010, 6'b001011, 6'b001100,
                  6'b001101, 6'b001110, 6'b001111};

      // reset state: all-zero inputs decode as a left shift by zero of zero
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_now("R5 reset", 32'h0, 1'b0);
      rst = 1'b0;

      // directed corners
      run(6'd0, 6'b100000, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, "R1 wrap");
      run(6'd0, 6'b100001, 5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, "R1 no trap");
      run(6'd0, 6'b100010, 5'd0, 32'h8000_0000, 32'h0000_0001, 16'h0, "R2 wrap");
      run(6'd0, 6'b100011, 5'd0, 32'h0, 32'h1, 16'h0, "R2 borrow");
      run(6'd0, 6'b100111, 5'd0, 32'h0F0F_0000, 32'h0000_00F0, 16'h0, "R3 nor");
      run(6'd0, 6'b101010, 5'd0, 32'h8000_0000, 32'h0000_0001, 16'h0, "R4 signed");
      run(6'd0, 6'b101011, 5'd0, 32'h8000_0000, 32'h0000_0001, 16'h0, "R4 unsigned");
      run(6'd0, 6'b101010, 5'd0, 32'h5, 32'h5, 16'h0, "R4 equal");
      run(6'd0, 6'b000000, 5'd31, 32'hDEAD_BEEF, 32'h0000_0003, 16'h0, "R5 sll rs ignored");
      run(6'd0, 6'b000010, 5'd4, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, "R5 srl");
      run(6'd0, 6'b000011, 5'd31, 32'h0, 32'h8000_0000, 16'h0, "R7 sra full");
      run(6'd0, 6'b000011, 5'd8, 32'h0, 32'h7000_0000, 16'h0, "R7 sra positive");
      run(6'd0, 6'b000100, 5'd7, 32'hFFFF_FFE4, 32'h0000_0001, 16'h0, "R6 sllv high bits");
      run(6'd0, 6'b000110, 5'd3, 32'h0000_0020, 32'hF000_0000, 16'h0, "R6 srlv by zero");
      run(6'd0, 6'b000111, 5'd1, 32'h0000_001F, 32'h8000_0000, 16'h0, "R7 srav");
      run(6'b001000, 6'd0, 5'd0, 32'h0000_0000, 32'h0, 16'hFFFF, "R8 negative imm");
      run(6'b001001, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h0001, "R8 wrap");
      run(6'b001010, 6'd0, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R9 signed");
      run(6'b001011, 6'd0, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R9 unsigned sext");
      run(6'b001100, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, "R10 andi zext");
      run(6'b001101, 6'd0, 5'd0, 32'h0, 32'h0, 16'h8000, "R10 ori zext");
      run(6'b001110, 6'd0, 5'd0, 32'hFFFF_0000, 32'h0, 16'hFFFF, "R10 xori");
      run(6'b001111, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h1234, "R11 lui");
      run(6'd0, 6'b001000, 5'd3, 32'h1234_5678, 32'h9, 16'h0, "R12 reg fn");
      run(6'b100011, 6'd0, 5'd0, 32'h1, 32'h1, 16'h7, "R12 opcode");

      // exhaustive sweep of every opcode and every function code
      for (int o = 0; o < 64; o++) begin
         if (o == 0) begin
            for (int f = 0; f < 64; f++)
               run(6'd0, f[5:0], 5'd9, 32'hC3A5_0F12, 32'h9876_5432, 16'hA5C3, tag_of(6'd0, f[5:0]));
         end else begin
            run(o[5:0], 6'b100000, 5'd2, 32'h8765_4321, 32'h1357_9BDF, 16'h9ABC, tag_of(o[5:0], 6'b100000));
         end
      end

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [5:0] o, f;
         o = 6'd0;
         f = 6'd0;
         case ($urandom % 4)
            0: f = reg_fns[$urandom % 16];
            1: o = imm_ops[$urandom % 8];
            2: begin o = 6'($urandom); f = 6'($urandom); end
            default: f = 6'($urandom);
         endcase
         run(o, f, 5'($urandom), pick_val(), pick_val(), 16'($urandom), tag_of(o, f));
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got running exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule